// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that sits on a simple register bus with address, write enable, write data and combinational read data. It derives a slow count tick from the core clock in two steps: an 8-bit programmable prescaler, then a fixed power-of-two divider chosen from four settings. Each tick moves a 16-bit down-counter one step toward zero. When the counter is already at zero and another tick arrives, the block reloads the counter from a reload register. It can also raise an interrupt pulse, a multi-cycle system reset pulse, or both. Each of these two outputs has its own enable bit.

Software keeps the system alive by writing a fresh value into the count register before the counter runs out. Clearing the run bit freezes the counter and holds both dividers in their cleared state. A short reset can also be forced on purpose: load a small count, pick a small division and enable reset.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset the control register reads 0x0000, the reload and count registers read 0x8000, and both the interrupt and reset outputs are low.
- R2: Byte offset 0x0 reads back the control register with only its defined fields (bit 0 reset enable, bit 2 interrupt enable, bits [4:3] divider select, bit 5 run, bits [15:8] prescale), other bits reading zero. Offset 0x4 reads the reload value and offset 0x8 reads the live count. All other offsets read zero.
- R3: While running, the counter steps down by one every (P+1)·D core cycles. P is the prescale field, and D is 16, 32, 64 or 128 for divider select 00, 01, 10 or 11.
- R4: A tick that finds the counter at zero loads the counter from the reload register instead of decrementing it.
- R5: With the interrupt enable set, each expiry gives an interrupt pulse exactly one cycle long, high in the cycle after the expiring tick.
- R6: With the reset enable set, each expiry drives the reset output high for RST_LEN (default 8) consecutive cycles, starting in the cycle after the expiring tick. The interrupt and reset enables act independently.
- R7: A write to offset 0x8 loads bits [15:0] of the write data into the counter. If a tick falls in the same cycle, the write wins: the tick is dropped and no expiry occurs.
- R8: With the run bit clear, the counter holds its value and no interrupt or reset pulse starts. The first tick after the run bit is set comes one full period (P+1)·D cycles later.
- R9: Any write to the control register restarts the tick phase and discards a tick due in that cycle, so the next tick comes one full period after the write.
- R10: With reset enabled, prescale 0x20, divide-by-16 and count 0x80, reset asserts 129·33·16 cycles after the control write that starts the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| wd_irq | output | 1 | One-cycle interrupt pulse on expiry |
| wd_rst | output | 1 | Reset pulse of RST_LEN cycles on expiry |

## Verification
A software kick and the divider's tick can land on the same clock edge. The block must then load the written value and drop the tick. If the counter was at zero, no expiry may happen. The bench provokes this by tracking the tick phase in its own model and writing the count register in exactly the cycle whose edge carries an expiring tick. It judges the result by the absence of any interrupt or reset pulse afterwards and by reading back the written count. A control write colliding with a due tick is provoked in the same way, and it must push the next tick a full period away.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Register byte offsets
  localparam int OFF_CTRL   = 'h0;
  localparam int OFF_RELOAD = 'h4;
  localparam int OFF_COUNT  = 'h8;

  // Control word field positions
  localparam int CB_RST_EN  = 0;
  localparam int CB_IRQ_EN  = 2;
  localparam int CB_DIV_LO  = 3;
  localparam int CB_RUN     = 5;
  localparam int CB_PRE_LO  = 8;

  localparam int PRE_W      = 8;
  localparam int SEL_W      = 2;
  localparam int DIV_BASE_LOG = 4;  // smallest fixed division is 2**4

  typedef struct packed {
    logic [PRE_W-1:0] prescale;
    logic             run;
    logic [SEL_W-1:0] div_sel;
    logic             irq_en;
    logic             rst_en;
  } ctrl_t;

  function automatic logic [15:0] ctrl_pack(input ctrl_t c);
    logic [15:0] w;
    w = '0;
    w[CB_PRE_LO +: PRE_W] = c.prescale;
    w[CB_RUN]             = c.run;
    w[CB_DIV_LO +: SEL_W] = c.div_sel;
    w[CB_IRQ_EN]          = c.irq_en;
    w[CB_RST_EN]          = c.rst_en;
    return w;
  endfunction

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         tick_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         hit;

  always_comb begin
    hit = !clear && (cnt_q == limit);
    if (clear || hit) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = hit;

  // R8
  pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

  // R3
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |-> (cnt_q <= limit));

endmodule

// File: rtl/wdog_divider.sv
module wdog_divider #(
  parameter int SEL_W    = 2,
  parameter int BASE_LOG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             in_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             tick_o
);

  localparam int CW = BASE_LOG + (1 << SEL_W) - 1;

  logic [CW-1:0] cnt_q, cnt_d, term;
  logic          wrap;

  always_comb begin
    term = CW'((32'd1 << (BASE_LOG + 32'(sel))) - 32'd1);
    wrap = in_tick && (cnt_q == term);
    if (clear || wrap) begin
      cnt_d = '0;
    end else if (in_tick) begin
      cnt_d = cnt_q + CW'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = wrap;

  // R3
  div_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));

  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_tick && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   INIT = 16'h8000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] count_o,
  output logic         expire_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         at_zero, expire;

  always_comb begin
    at_zero = (cnt_q == '0);
    expire  = tick && !load && at_zero;
    if (load) begin
      cnt_d = load_val;
    end else if (expire) begin
      cnt_d = reload_val;
    end else if (tick) begin
      cnt_d = cnt_q - W'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= INIT;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o  = cnt_q;
  assign expire_o = expire;

  // R4
  cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == $past(reload_val)));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - W'(1)));

  // R8
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int LEN = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_o
);

  generate
    if (LEN == 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= 1'b0;
        end else begin
          q <= fire;
        end
      end
      assign pulse_o = q;
    end else begin : g_stretch
      localparam int CW = $clog2(LEN + 1);
      logic [CW-1:0] left_q, left_d;
      always_comb begin
        if (fire) begin
          left_d = CW'(LEN);
        end else if (left_q != '0) begin
          left_d = left_q - CW'(1);
        end else begin
          left_d = left_q;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          left_q <= '0;
        end else begin
          left_q <= left_d;
        end
      end
      assign pulse_o = (left_q != '0);

      // R6
      pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |=> pulse_o);
    end
  endgenerate

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int              ADDR_W     = 4,
  parameter int              DATA_W     = 32,
  parameter int              CNT_W      = 16,
  parameter int              RST_LEN    = 8,
  parameter logic [CNT_W-1:0] COUNT_INIT = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_irq,
  output logic              wd_rst
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign srst_n = rsync_q[1];

  // Address decode
  logic hit_ctrl, hit_reload, hit_count;
  logic ctrl_wr, reload_wr, count_wr;

  always_comb begin
    hit_ctrl   = (bus_addr == ADDR_W'(OFF_CTRL));
    hit_reload = (bus_addr == ADDR_W'(OFF_RELOAD));
    hit_count  = (bus_addr == ADDR_W'(OFF_COUNT));
    ctrl_wr    = bus_we && hit_ctrl;
    reload_wr  = bus_we && hit_reload;
    count_wr   = bus_we && hit_count;
  end

  // Control register
  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.prescale = bus_wdata[CB_PRE_LO +: PRE_W];
      ctrl_d.run      = bus_wdata[CB_RUN];
      ctrl_d.div_sel  = bus_wdata[CB_DIV_LO +: SEL_W];
      ctrl_d.irq_en   = bus_wdata[CB_IRQ_EN];
      ctrl_d.rst_en   = bus_wdata[CB_RST_EN];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  logic wdata_unused;
  assign wdata_unused = ^{bus_wdata[DATA_W-1:16], bus_wdata[7:6], bus_wdata[1]};

  // Reload register
  logic [CNT_W-1:0] reload_q, reload_d;

  always_comb begin
    reload_d = reload_wr ? bus_wdata[CNT_W-1:0] : reload_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      reload_q <= COUNT_INIT;
    end else begin
      reload_q <= reload_d;
    end
  end

  // Tick chain
  logic div_clear, pre_tick, cnt_tick;
  assign div_clear = !ctrl_q.run || ctrl_wr;

  wdog_prescaler #(.W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (srst_n),
    .clear  (div_clear),
    .limit  (ctrl_q.prescale),
    .tick_o (pre_tick)
  );

  wdog_divider #(.SEL_W(SEL_W), .BASE_LOG(DIV_BASE_LOG)) u_div (
    .clk     (clk),
    .rst_n   (srst_n),
    .clear   (div_clear),
    .in_tick (pre_tick),
    .sel     (ctrl_q.div_sel),
    .tick_o  (cnt_tick)
  );

  // Down-counter
  logic [CNT_W-1:0] count_val;
  logic             expire;

  wdog_counter #(.W(CNT_W), .INIT(COUNT_INIT)) u_cnt (
    .clk        (clk),
    .rst_n      (srst_n),
    .tick       (cnt_tick),
    .load       (count_wr),
    .load_val   (bus_wdata[CNT_W-1:0]),
    .reload_val (reload_q),
    .count_o    (count_val),
    .expire_o   (expire)
  );

  // Expiry outputs
  logic irq_fire, rst_fire;
  assign irq_fire = expire && ctrl_q.irq_en;
  assign rst_fire = expire && ctrl_q.rst_en;

  wdog_pulse #(.LEN(1)) u_irq (
    .clk     (clk),
    .rst_n   (srst_n),
    .fire    (irq_fire),
    .pulse_o (wd_irq)
  );

  wdog_pulse #(.LEN(RST_LEN)) u_rst (
    .clk     (clk),
    .rst_n   (srst_n),
    .fire    (rst_fire),
    .pulse_o (wd_rst)
  );

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata = DATA_W'(ctrl_pack(ctrl_q));
    end else if (hit_reload) begin
      bus_rdata = DATA_W'(reload_q);
    end else if (hit_count) begin
      bus_rdata = DATA_W'(count_val);
    end
  end

  // R7
  kick_load_chk: assert property (@(posedge clk) disable iff (!srst_n)
    count_wr |=> (count_val == $past(bus_wdata[CNT_W-1:0])));

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wd_irq |=> !wd_irq);

  // R8
  stop_no_rst_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !ctrl_q.run |=> !$rose(wd_rst));

  // R8
  stop_no_irq_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !ctrl_q.run |=> !wd_irq);

  // R9
  ctrl_wr_notick_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ctrl_wr |-> !cnt_tick);

endmodule

// File: tb/tb_wdog_timer.sv
`timescale 1ns/1ps
module tb_wdog_timer;

  localparam int RST_LEN = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq, rst;

  always #2 clk = ~clk;

  wdog_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .wd_irq(irq), .wd_rst(rst)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference model state
  logic [15:0] m_ctrl, m_reload, m_count;
  int          m_phase, m_rcnt;
  bit          m_irq;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'h0: return {16'h0, m_ctrl};
      4'h4: return {16'h0, m_reload};
      4'h8: return {16'h0, m_count};
      default: return 32'h0;
    endcase
  endfunction

  function automatic int period(input logic [15:0] c);
    return (int'(c[15:8]) + 1) * (16 << c[4:3]);
  endfunction

  task automatic model_step(input logic w, input logic [3:0] a, input logic [31:0] d);
    bit run, cw, lw, kw, tick, expire;
    run    = m_ctrl[5];
    cw     = w && a == 4'h0;
    lw     = w && a == 4'h4;
    kw     = w && a == 4'h8;
    tick   = run && !cw && (m_phase == period(m_ctrl) - 1);
    expire = tick && !kw && (m_count == 16'h0);
    m_irq  = expire && m_ctrl[2];
    if (expire && m_ctrl[0]) m_rcnt = RST_LEN;
    else if (m_rcnt > 0)     m_rcnt = m_rcnt - 1;
    if (!run || cw || tick) m_phase = 0;
    else                    m_phase = m_phase + 1;
    if (kw)          m_count = d[15:0];
    else if (expire) m_count = m_reload;
    else if (tick)   m_count = m_count - 16'd1;
    if (cw) m_ctrl = d[15:0] & 16'hFF3D;
    if (lw) m_reload = d[15:0];
  endtask

  // One cycle: drive at the falling edge, compare, advance model, cross the rising edge
  task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d);
    we = w; addr = a; wdata = d;
    #1;
    chk(irq === m_irq, "R5 irq output", irq, m_irq);
    chk(rst === (m_rcnt != 0), "R6 reset output", rst, (m_rcnt != 0));
    if (!w) chk(rdata === m_read(a), (a == 4'h8) ? "R3 count read" : "R2 register read",
                rdata, m_read(a));
    model_step(w, a, d);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'h8, 32'h0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(1'b1, a, d);
  endtask

  task automatic peek(input logic [3:0] a, output logic [31:0] v);
    we = 1'b0; addr = a; #1; v = rdata;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual run still going, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int hi, other, cap;
    void'($urandom(32'd2024));
    rst_n = 1'b0; we = 1'b0; addr = 4'h0; wdata = '0;
    m_ctrl = 16'h0; m_reload = 16'h8000; m_count = 16'h8000;
    m_phase = 0; m_rcnt = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(4'h0, v); chk(v == 32'h0, "R1 control after reset", v, 0);
    peek(4'h4, v); chk(v == 32'h8000, "R1 reload after reset", v, 32'h8000);
    peek(4'h8, v); chk(v == 32'h8000, "R1 count after reset", v, 32'h8000);
    chk(!irq && !rst, "R1 outputs after reset", {irq, rst}, 0);

    // R2 field masking and unmapped offset
    wr(4'h0, 32'hFFFF_FFDF);
    peek(4'h0, v); chk(v == 32'hFF1D, "R2 control readback", v, 32'hFF1D);
    peek(4'hC, v); chk(v == 32'h0, "R2 unmapped offset", v, 0);
    wr(4'h0, 32'h0);

    // R4 R5: interrupt only, count 1, reload 3
    wr(4'h4, 32'h3); wr(4'h8, 32'h1); wr(4'h0, 32'h24);
    hi = 0; other = 0; cap = -1;
    for (int i = 0; i < 80; i++) begin
      cyc(1'b0, 4'h8, 32'h0);
      if (irq) begin hi++; if (cap < 0) cap = int'(rdata); end
      if (rst) other++;
    end
    chk(hi == 1, "R5 single interrupt cycle", hi, 1);
    chk(cap == 3, "R4 reload on expiry", cap, 3);
    chk(other == 0, "R6 reset stays low when disabled", other, 0);
    wr(4'h0, 32'h0);

    // R6: reset only, count 0
    wr(4'h8, 32'h0); wr(4'h0, 32'h21);
    hi = 0; other = 0;
    for (int i = 0; i < 60; i++) begin
      cyc(1'b0, 4'h8, 32'h0);
      if (rst) hi++;
      if (irq) other++;
    end
    chk(hi == RST_LEN, "R6 reset pulse length", hi, RST_LEN);
    chk(other == 0, "R5 interrupt stays low when disabled", other, 0);
    wr(4'h0, 32'h0);

    // R7: kick in the same cycle as an expiring tick
    wr(4'h4, 32'h7); wr(4'h8, 32'h0); wr(4'h0, 32'h25);
    idle(15);
    wr(4'h8, 32'h9);
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      cyc(1'b0, 4'h8, 32'h0);
      if (irq || rst) hi++;
    end
    chk(hi == 0, "R7 kick suppresses expiry", hi, 0);
    peek(4'h8, v); chk(v == 32'h9, "R7 kick value loaded", v, 9);
    wr(4'h0, 32'h0);

    // R8: stopping freezes the counter
    wr(4'h8, 32'h3); wr(4'h0, 32'h25);
    idle(20);
    wr(4'h0, 32'h5);
    peek(4'h8, v); chk(v == 32'h2, "R3 one tick in twenty cycles", v, 2);
    hi = 0;
    for (int i = 0; i < 1000; i++) begin
      cyc(1'b0, 4'h8, 32'h0);
      if (irq || rst) hi++;
    end
    peek(4'h8, v); chk(v == 32'h2, "R8 count held while stopped", v, 2);
    chk(hi == 0, "R8 no pulses while stopped", hi, 0);

    // R8 R3: first tick a full period after enable, P=2, /32
    wr(4'h8, 32'h5); wr(4'h0, 32'h228);
    idle(95);
    peek(4'h8, v); chk(v == 32'h5, "R8 no early first tick", v, 5);
    idle(1);
    peek(4'h8, v); chk(v == 32'h4, "R3 tick after 96 cycles", v, 4);

    // R9: control rewrite restarts the phase
    idle(50);
    wr(4'h0, 32'h228);
    idle(95);
    peek(4'h8, v); chk(v == 32'h4, "R9 phase restarted", v, 4);
    idle(1);
    peek(4'h8, v); chk(v == 32'h3, "R9 tick one period after rewrite", v, 3);
    wr(4'h0, 32'h0);

    // Random mix of settings, kicks and reads
    for (int r = 0; r < 30; r++) begin
      logic [31:0] c;
      c = {16'h0, 8'($urandom % 4), 2'b0, 1'b1, 2'($urandom), 1'($urandom), 1'b0, 1'($urandom)};
      wr(4'h4, $urandom % 12);
      wr(4'h8, $urandom % 12);
      wr(4'h0, c);
      for (int i = 0; i < 500; i++) begin
        int p;
        p = $urandom % 200;
        if (p < 4)       wr(4'h8, $urandom % 12);
        else if (p == 4) wr(4'h4, $urandom % 12);
        else if (p == 5) wr(4'h0, c);
        else begin
          logic [3:0] ra;
          ra = 4'(($urandom % 4) * 4);
          cyc(1'b0, ra, 32'h0);
        end
      end
    end
    wr(4'h0, 32'h0);
    idle(RST_LEN + 2);

    // R10: prescale 0x20, /16, count 0x80, reset enabled
    wr(4'h4, 32'h80); wr(4'h8, 32'h80); wr(4'h0, 32'h2021);
    idle(129 * 33 * 16 - 1);
    chk(rst == 1'b0, "R10 reset not yet asserted", rst, 0);
    idle(1);
    chk(rst == 1'b1, "R10 reset asserted on time", rst, 1);
    wr(4'h0, 32'h0);
    idle(RST_LEN + 2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule